// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block sits beside a DDR SDRAM command bus and samples it on every rising clock edge. From the clock-enable level of the previous and the current cycle, together with the chip-select, row-strobe, column-strobe and write-enable pins, it names the command that was issued. It reports that command with its bank, its auto-precharge bit and its address one cycle later.

It keeps an open or idle flag for each of the four banks. It remembers the burst length programmed through the mode register. It times two windows: the pause required after a mode-register write, and the burst-plus-precharge interval that follows a write with auto-precharge. Any command that breaks an issue rule sets a sticky error bit and raises a one-cycle pulse. A command that breaks a rule has no effect on the tracked state. Integration or verification logic can use the block to catch controller bugs without modelling the memory.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With clock-enable high in both cycles and chip select high, the command is NOP. With chip select low, the pins {RAS,CAS,WE} decode as follows: HHH is NOP; LLL is a mode-register write (code 1 when BA0=0, extended code 2 when BA0=1); LLH is auto refresh (9); LHH is activate (3); HLH is read (4); HLL is write (5); HHL is burst stop (6); LHL is precharge (7 when A10=0, all-bank code 8 when A10=1).
- R2: Clock-enable low in both cycles gives NOP (0), whatever the pins. A low-to-high transition gives exit (13). A high-to-low transition with the refresh pattern gives self-refresh entry (10). A high-to-low transition with NOP or deselect gives power-down entry: 11 if any bank is open, 12 if all banks are idle. Any other pattern on a high-to-low transition is NOP.
- R3: The outputs cmd_o, bank_o, addr_o and ap_o show the command sampled at a rising edge, starting just after that edge. bank_o equals BA. ap_o equals A10 for codes 4, 5, 7 and 8, and is 0 for all other codes.
- R4: Reset sets all banks idle. An accepted activate opens bank BA. Precharge, or read or write with A10=1, closes bank BA. All-bank precharge closes every bank. bank_open_o bit n is bank n.
- R5: An activate to an open bank, or a read or write to an idle bank, sets err_o[0].
- R6: A mode-register write, extended mode-register write, auto refresh or self-refresh entry while any bank is open sets err_o[1].
- R7: After an accepted mode-register write of either kind, any command other than NOP in the next MRS_GAP-1 cycles sets err_o[2].
- R8: An accepted normal mode-register write sets the burst length from A2:A0: 001 gives 2, 010 gives 4, 011 gives 8. Any other value keeps the current burst length. Reset sets the burst length to 4.
- R9: After an accepted write with A10=1, a read or write in the next BL/2 cycles sets err_o[3]. An activate to that same bank in the next BL/2+TRP cycles also sets err_o[3].
- R10: A command that sets any error bit changes neither bank state, burst length nor timers. Error bits stay set until reset. err_pulse_o is high for exactly the cycle after each violating command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cke_prev | input | 1 | Clock-enable level of the previous cycle |
| cke_cur | input | 1 | Clock-enable level of the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row/column address, A10 is auto-precharge / all-bank |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Bank of the reported command |
| addr_o | output | 13 | Address of the reported command |
| ap_o | output | 1 | Auto-precharge / all-bank bit of the reported command |
| bank_open_o | output | 4 | Open flag per bank |
| err_o | output | 4 | Sticky errors: 0 bank state, 1 not all idle, 2 mode gap, 3 write auto-precharge |
| err_pulse_o | output | 1 | One-cycle flag for a violating command |

## Verification
The bench builds the block with TRP=2 and MRS_GAP=3. A gap of three gives a two-cycle blocked window after a mode-register write, so the gap counter must count down through more than one step. A shorter TRP lets directed sequences with burst length 2 reach both edges of the write auto-precharge window: the first cycle where a read is allowed, and the last cycle where an activate to the same bank is still refused. Random traffic with occasional clock-enable drops and periodic resets covers the power-down and self-refresh decodes with banks both open and idle.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_EMRS = 4'd2,
    CMD_ACT  = 4'd3,
    CMD_RD   = 4'd4,
    CMD_WR   = 4'd5,
    CMD_BST  = 4'd6,
    CMD_PRE  = 4'd7,
    CMD_PREA = 4'd8,
    CMD_AREF = 4'd9,
    CMD_SREF = 4'd10,
    CMD_PDA  = 4'd11,
    CMD_PDP  = 4'd12,
    CMD_EXIT = 4'd13
  } cmd_e;

  localparam int ERR_BANK = 0;
  localparam int ERR_IDLE = 1;
  localparam int ERR_GAP  = 2;
  localparam int ERR_WAP  = 3;
  localparam int NUM_ERR  = 4;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cke_cur,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ba0,
  input  logic a10,
  input  logic any_open,
  output cmd_e cmd
);
  logic [2:0] pins;
  cmd_e       pin_cmd;

  assign pins = {ras_n, cas_n, we_n};

  // pin-level decode, valid only when clock-enable stays high
  always_comb begin
    pin_cmd = CMD_NOP;
    if (!cs_n) begin
      case (pins)
        3'b000:  pin_cmd = ba0 ? CMD_EMRS : CMD_MRS;
        3'b001:  pin_cmd = CMD_AREF;
        3'b011:  pin_cmd = CMD_ACT;
        3'b101:  pin_cmd = CMD_RD;
        3'b100:  pin_cmd = CMD_WR;
        3'b110:  pin_cmd = CMD_BST;
        3'b010:  pin_cmd = a10 ? CMD_PREA : CMD_PRE;
        default: pin_cmd = CMD_NOP;
      endcase
    end
  end

  // clock-enable transitions take priority over the pins
  always_comb begin
    case ({cke_prev, cke_cur})
      2'b11: cmd = pin_cmd;
      2'b01: cmd = CMD_EXIT;
      2'b10: begin
        if (!cs_n && pins == 3'b001)
          cmd = CMD_SREF;
        else if (cs_n || pins == 3'b111)
          cmd = any_open ? CMD_PDA : CMD_PDP;
        else
          cmd = CMD_NOP;
      end
      default: cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BAW = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cmd_e                 cmd,
  input  logic [BAW-1:0]       ba,
  input  logic                 ap,
  input  logic                 accept,
  output logic [NUM_BANKS-1:0] open_q
);
  logic closes_one;

  assign closes_one = (cmd == CMD_PRE) ||
                      (((cmd == CMD_RD) || (cmd == CMD_WR)) && ap);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        open_q[b] <= 1'b0;
      else if (accept) begin
        if (cmd == CMD_ACT && ba == BAW'(b))
          open_q[b] <= 1'b1;
        else if (cmd == CMD_PREA)
          open_q[b] <= 1'b0;
        else if (closes_one && ba == BAW'(b))
          open_q[b] <= 1'b0;
      end
    end

    // R4
    open_only_by_act_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(open_q[b]) |-> $past(accept && cmd == CMD_ACT && ba == BAW'(b)));
  end

  // R4
  prea_closes_all_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd == CMD_PREA) |=> (open_q == '0));
endmodule

// File: rtl/ddr_issue_rules.sv
module ddr_issue_rules
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRP       = 3,
  parameter int MRS_GAP   = 2,
  localparam int BAW      = $clog2(NUM_BANKS),
  localparam int WAP_MAX  = 4 + TRP,
  localparam int WW       = $clog2(WAP_MAX + 1),
  localparam int GW       = $clog2(MRS_GAP + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cmd_e                 cmd,
  input  logic [BAW-1:0]       ba,
  input  logic                 ap,
  input  logic [2:0]           op_bl,
  input  logic [NUM_BANKS-1:0] open_q,
  output logic [NUM_ERR-1:0]   viol,
  output logic                 accept
);
  logic [GW-1:0]  gap_cnt;
  logic [WW-1:0]  wap_cnt;
  logic [BAW-1:0] wap_bank;
  logic [2:0]     bl_half;
  logic           is_rw;
  logic           needs_idle;

  assign is_rw      = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign needs_idle = cmd inside {CMD_MRS, CMD_EMRS, CMD_AREF, CMD_SREF};

  always_comb begin
    viol           = '0;
    viol[ERR_BANK] = (cmd == CMD_ACT && open_q[ba]) || (is_rw && !open_q[ba]);
    viol[ERR_IDLE] = needs_idle && (|open_q);
    viol[ERR_GAP]  = (gap_cnt != '0) && (cmd != CMD_NOP);
    viol[ERR_WAP]  = (is_rw && (int'(wap_cnt) > TRP)) ||
                     (cmd == CMD_ACT && ba == wap_bank && wap_cnt != '0);
  end

  assign accept = ~|viol;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      wap_cnt  <= '0;
      wap_bank <= '0;
      bl_half  <= 3'd2;
    end else begin
      if (accept && (cmd == CMD_MRS || cmd == CMD_EMRS))
        gap_cnt <= GW'(MRS_GAP - 1);
      else if (gap_cnt != '0)
        gap_cnt <= gap_cnt - 1'b1;

      if (accept && cmd == CMD_WR && ap) begin
        wap_cnt  <= WW'(bl_half) + WW'(TRP);
        wap_bank <= ba;
      end else if (wap_cnt != '0)
        wap_cnt <= wap_cnt - 1'b1;

      if (accept && cmd == CMD_MRS) begin
        case (op_bl)
          3'b001:  bl_half <= 3'd1;
          3'b010:  bl_half <= 3'd2;
          3'b011:  bl_half <= 3'd4;
          default: bl_half <= bl_half;
        endcase
      end
    end
  end

  if (MRS_GAP > 1) begin : g_gap_chk
    // R7
    mrs_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (accept && (cmd == CMD_MRS || cmd == CMD_EMRS)) |=>
        ((cmd != CMD_NOP) |-> viol[ERR_GAP]));
  end

  // R9
  wap_rw_block_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd == CMD_WR && ap) |=> (is_rw |-> viol[ERR_WAP]));

  // R8
  bl_legal_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(bl_half) == 1 && bl_half != 3'd0);
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int TRP       = 3,
  parameter int MRS_GAP   = 2,
  localparam int BAW      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke_prev,
  input  logic                 cke_cur,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BAW-1:0]       ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [3:0]           cmd_o,
  output logic [BAW-1:0]       bank_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 ap_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic [NUM_ERR-1:0]   err_o,
  output logic                 err_pulse_o
);
  cmd_e               cmd_now;
  logic [NUM_ERR-1:0] viol;
  logic               accept;
  logic               ap_bit;
  logic               ap_cmd;

  assign ap_bit = addr[10];
  assign ap_cmd = cmd_now inside {CMD_RD, CMD_WR, CMD_PRE, CMD_PREA};

  ddr_cmd_decode u_decode (
    .cke_prev (cke_prev),
    .cke_cur  (cke_cur),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba0      (ba[0]),
    .a10      (ap_bit),
    .any_open (|bank_open_o),
    .cmd      (cmd_now)
  );

  ddr_issue_rules #(
    .NUM_BANKS (NUM_BANKS),
    .TRP       (TRP),
    .MRS_GAP   (MRS_GAP)
  ) u_rules (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd_now),
    .ba     (ba),
    .ap     (ap_bit),
    .op_bl  (addr[2:0]),
    .open_q (bank_open_o),
    .viol   (viol),
    .accept (accept)
  );

  ddr_bank_tracker #(
    .NUM_BANKS (NUM_BANKS)
  ) u_banks (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd_now),
    .ba     (ba),
    .ap     (ap_bit),
    .accept (accept),
    .open_q (bank_open_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o       <= 4'd0;
      bank_o      <= '0;
      addr_o      <= '0;
      ap_o        <= 1'b0;
      err_o       <= '0;
      err_pulse_o <= 1'b0;
    end else begin
      cmd_o       <= cmd_now;
      bank_o      <= ba;
      addr_o      <= addr;
      ap_o        <= ap_cmd & ap_bit;
      err_o       <= err_o | viol;
      err_pulse_o <= |viol;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o & $past(err_o)) == $past(err_o));

  // R10
  pulse_has_err_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse_o |-> (err_o != '0));

  // R2
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (!cke_prev && !cke_cur) |=> (cmd_o == 4'd0));
endmodule

// File: tb/test_ddr_cmd_monitor.sv
module test_ddr_cmd_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int TRP        = 2;
  localparam int MRS_GAP    = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke_prev = 1'b1, cke_cur = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'd0;
  logic [12:0] addr = 13'd0;
  logic [3:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] addr_o;
  logic        ap_o;
  logic [3:0]  bank_open_o;
  logic [3:0]  err_o;
  logic        err_pulse_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [3:0]  m_open;
  logic [3:0]  m_err;
  int          m_gap, m_wap, m_blh;
  logic [1:0]  m_wb;
  logic [3:0]  e_cmd;
  logic [1:0]  e_bank;
  logic [12:0] e_addr;
  logic        e_ap, e_pulse;
  logic        held_cke = 1'b1;

  ddr_cmd_monitor #(.TRP(TRP), .MRS_GAP(MRS_GAP)) i_ddr_cmd_monitor (
    .clk(clk), .rst(rst), .cke_prev(cke_prev), .cke_cur(cke_cur),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o),
    .ap_o(ap_o), .bank_open_o(bank_open_o), .err_o(err_o),
    .err_pulse_o(err_pulse_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_decode(logic cp, logic cc, logic [3:0] p,
                                            logic ba0, logic a10, logic anyo);
    if (!cp && !cc) return 4'd0;
    if (!cp && cc) return 4'd13;
    if (cp && !cc) begin
      if (p == 4'b0001) return 4'd10;
      if (p[3] || p == 4'b0111) return anyo ? 4'd11 : 4'd12;
      return 4'd0;
    end
    if (p[3]) return 4'd0;
    case (p[2:0])
      3'b000:  return ba0 ? 4'd2 : 4'd1;
      3'b001:  return 4'd9;
      3'b011:  return 4'd3;
      3'b101:  return 4'd4;
      3'b100:  return 4'd5;
      3'b110:  return 4'd6;
      3'b010:  return a10 ? 4'd8 : 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_open = '0; m_err = '0; m_gap = 0; m_wap = 0; m_blh = 2; m_wb = '0;
  endtask

  task automatic model_step(logic cp, logic cc, logic [3:0] p, logic [1:0] b,
                            logic [12:0] a);
    logic [3:0] c, v;
    logic rw, acc;
    c  = exp_decode(cp, cc, p, b[0], a[10], |m_open);
    rw = (c == 4'd4) || (c == 4'd5);
    v  = '0;
    v[0] = (c == 4'd3 && m_open[b]) || (rw && !m_open[b]);
    v[1] = (c == 4'd1 || c == 4'd2 || c == 4'd9 || c == 4'd10) && (m_open != 0);
    v[2] = (m_gap > 0) && (c != 4'd0);
    v[3] = (rw && m_wap > TRP) || (c == 4'd3 && b == m_wb && m_wap > 0);
    acc  = (v == 0);
    e_cmd = c; e_bank = b; e_addr = a;
    e_ap  = (c == 4'd4 || c == 4'd5 || c == 4'd7 || c == 4'd8) ? a[10] : 1'b0;
    e_pulse = (v != 0);
    m_err = m_err | v;
    if (acc && (c == 4'd1 || c == 4'd2)) m_gap = MRS_GAP - 1;
    else if (m_gap > 0) m_gap--;
    if (acc && c == 4'd5 && a[10]) begin m_wap = m_blh + TRP; m_wb = b; end
    else if (m_wap > 0) m_wap--;
    if (acc && c == 4'd1) begin
      if (a[2:0] == 3'b001) m_blh = 1;
      else if (a[2:0] == 3'b010) m_blh = 2;
      else if (a[2:0] == 3'b011) m_blh = 4;
    end
    if (acc) begin
      if (c == 4'd3) m_open[b] = 1'b1;
      else if (c == 4'd8) m_open = '0;
      else if (c == 4'd7 || (rw && a[10])) m_open[b] = 1'b0;
    end
  endtask

  // p = {cs_n, ras_n, cas_n, we_n}
  task automatic step(string req, logic cke, logic [3:0] p, logic [1:0] b,
                      logic [12:0] a);
    logic cp;
    @(negedge clk);
    cp = held_cke;
    cke_prev = cp; cke_cur = cke; held_cke = cke;
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b; addr = a;
    @(posedge clk);
    model_step(cp, cke, p, b, a);
    #(CLK_PERIOD/4);
    chk((cp && cke) ? "R1" : "R2", "cmd_o", cmd_o, e_cmd);
    chk("R3", "bank_o", bank_o, e_bank);
    chk("R3", "addr_o", addr_o, e_addr);
    chk("R3", "ap_o", ap_o, e_ap);
    chk("R4", "bank_open_o", bank_open_o, m_open);
    chk(req, "err_o", err_o, m_err);
    chk("R10", "err_pulse_o", err_pulse_o, e_pulse);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cke_prev = 1'b1; cke_cur = 1'b1; held_cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R4", "reset bank_open_o", bank_open_o, 0);
    chk("R10", "reset err_o", err_o, 0);
    chk("R3", "reset cmd_o", cmd_o, 0);
  endtask

  localparam logic [3:0] P_NOP = 4'b0111, P_DES = 4'b1111, P_MRS = 4'b0000,
                         P_REF = 4'b0001, P_ACT = 4'b0011, P_RD  = 4'b0101,
                         P_WR  = 4'b0100, P_PRE = 4'b0010;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // R1 / R3 / R4: activate then read with auto-precharge
    step("R1", 1'b1, P_ACT, 2'd2, 13'h0155);
    chk("R1", "act code", cmd_o, 3);
    chk("R4", "bank2 open", bank_open_o, 4'b0100);
    step("R3", 1'b1, P_RD, 2'd2, 13'h0400);
    chk("R3", "ap_o on read", ap_o, 1);
    chk("R4", "read-ap closes", bank_open_o, 0);
    step("R1", 1'b1, P_MRS, 2'd1, 13'h0000);
    chk("R1", "extended mode code", cmd_o, 2);
    step("R1", 1'b1, P_NOP, 2'd0, 0);
    step("R1", 1'b1, P_NOP, 2'd0, 0);

    // R5: read to idle bank
    step("R5", 1'b1, P_RD, 2'd0, 0);
    chk("R5", "err bank bit", err_o[0], 1);
    chk("R5", "state unchanged", bank_open_o, 0);

    // R6: refresh with a bank open
    do_reset();
    step("R6", 1'b1, P_ACT, 2'd1, 0);
    step("R6", 1'b1, P_REF, 2'd0, 0);
    chk("R6", "err idle bit", err_o, 4'b0010);

    // R7: command inside gap window
    do_reset();
    step("R7", 1'b1, P_MRS, 2'd0, 13'd3);
    step("R7", 1'b1, P_NOP, 2'd0, 0);
    step("R7", 1'b1, P_ACT, 2'd0, 0);
    chk("R7", "err gap bit", err_o, 4'b0100);
    chk("R10", "rejected act", bank_open_o, 0);

    // R8 / R9: burst length 2, write auto-precharge window edges
    do_reset();
    step("R8", 1'b1, P_MRS, 2'd0, 13'd1);
    step("R8", 1'b1, P_NOP, 2'd0, 0);
    step("R8", 1'b1, P_NOP, 2'd0, 0);
    step("R8", 1'b1, P_ACT, 2'd0, 0);
    step("R8", 1'b1, P_ACT, 2'd1, 0);
    step("R9", 1'b1, P_WR, 2'd1, 13'h0400);
    step("R9", 1'b1, P_NOP, 2'd0, 0);
    step("R8", 1'b1, P_RD, 2'd0, 0);
    chk("R8", "read after BL2 burst", err_o, 0);
    step("R9", 1'b1, P_ACT, 2'd1, 0);
    chk("R9", "act inside trp", err_o, 4'b1000);
    step("R9", 1'b1, P_ACT, 2'd1, 0);
    chk("R9", "act after trp", bank_open_o, 4'b0011);

    // R2: clock-enable transitions
    do_reset();
    step("R2", 1'b0, P_DES, 2'd0, 0);
    chk("R2", "precharge power-down", cmd_o, 12);
    step("R2", 1'b1, P_MRS, 2'd0, 0);
    chk("R2", "exit", cmd_o, 13);
    step("R2", 1'b1, P_ACT, 2'd3, 0);
    step("R2", 1'b0, P_NOP, 2'd0, 0);
    chk("R2", "active power-down", cmd_o, 11);
    step("R2", 1'b0, P_MRS, 2'd0, 0);
    chk("R2", "suspended decode", cmd_o, 0);
    step("R2", 1'b1, P_NOP, 2'd0, 0);
    step("R2", 1'b1, P_PRE, 2'd0, 13'h0400);
    step("R2", 1'b0, P_REF, 2'd0, 0);
    chk("R2", "self-refresh entry", cmd_o, 10);
    step("R2", 1'b1, P_NOP, 2'd0, 0);
    chk("R2", "no errors", err_o, 0);

    // random traffic checked against the model
    for (int n = 0; n < 4000; n++) begin
      logic kc;
      logic [3:0] p;
      if (n % 250 == 0) do_reset();
      kc = held_cke ? ($urandom % 12 != 0) : ($urandom % 3 == 0);
      p  = ($urandom % 10 == 0) ? 4'b1000 | 4'($urandom % 8) : 4'($urandom % 8);
      if ($urandom % 3 == 0) p = P_NOP;
      step("R10", kc, p, 2'($urandom % 4),
           {2'b00, 1'($urandom % 2), 7'($urandom), 3'($urandom % 4)});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule